// File: doc/BRIEF.md
# Four-Flag Floating-Point Branch Resolver

This block handles one coprocessor-1 conditional branch. It reads a 32-bit instruction word, the address of that instruction, an 8-bit vector of floating-point condition flags and a coprocessor-usable qualifier. The branch tests an aligned group of four consecutive flags, chosen by a 3-bit field. In the true-sense form the branch is taken if any flag in the group is 1. In the false-sense form it is taken if any flag in the group is 0.

The decode results are combinational outputs for the step on which `valid_i` is high:
- a recognised flag,
- a taken flag,
- the target address,
- a misalignment flag,
- a coprocessor-unusable flag.

The branch has a delay slot, so the redirect is held in a pending register. It is released as a one-cycle registered pulse with the target address only after the next valid step, which is the delay-slot instruction, has been consumed. While a redirect is pending, no new branch is accepted.

Top module: `fp4_branch_resolver`

## Requirements
- R1: `recog_o` is 1 exactly when `valid_i` is 1, `instr_i[31:26]` is 6'b010001 and `instr_i[25:21]` is 5'b01010. Flipping any one of these eleven bits, or dropping `valid_i`, gives `recog_o` = 0.
- R2: When `instr_i[16]` (sense bit) is 1, with aligned group select `c = instr_i[20:18]`, coprocessor usable and nothing pending, `taken_o` is 1 exactly when any of `flags_i[c+3:c]` is 1.
- R3: When `instr_i[16]` is 0 under the same conditions, `taken_o` is 1 exactly when any of `flags_i[c+3:c]` is 0.
- R4: When `instr_i[19:18]` is not zero and the coprocessor is usable, `misalign_o` is 1 and `taken_o` is 0, whatever the flags hold.
- R5: For a recognised word with `cop_usable_i` = 0, `cop_unusable_o` is 1, while `taken_o` and `misalign_o` are both 0.
- R6: `target_o` equals `pc_i + 4 + sign_extend({instr_i[15:0], 2'b00})` modulo 2^32. This gives a reach of ±128 KB around the delay-slot address.
- R7: `instr_i[17]` has no effect on any output.
- R8: After a taken step, `redirect_o` stays 0 through the delay-slot step. It is then high for exactly one cycle following the clock edge that consumes the next valid step, with `redirect_pc_o` equal to the branch's target.
- R9: While a redirect is pending, `taken_o` is 0 even for a branch that would otherwise be taken, and that branch never produces a redirect.
- R10: Reset clears the pending redirect: `redirect_o` is 0 after reset, and a redirect pending at reset is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | One instruction step this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| flags_i | input | 8 | Floating-point condition flags |
| cop_usable_i | input | 1 | Coprocessor 1 is enabled |
| recog_o | output | 1 | Word is the any-of-four branch |
| taken_o | output | 1 | Branch accepted as taken |
| target_o | output | 32 | Branch target address |
| misalign_o | output | 1 | Group select is not a multiple of 4 |
| cop_unusable_o | output | 1 | Coprocessor-unusable exception |
| redirect_o | output | 1 | Apply redirect (one-cycle pulse) |
| redirect_pc_o | output | 32 | Address to redirect to |

## Verification
The hardest situation to reach is a would-be-taken branch arriving in the delay slot of another taken branch, because it needs two back-to-back qualifying steps. The bench builds this case directly. It then checks that only the first target emerges and that no second pulse follows. A reset that lands while a redirect is pending is also forced, and the bench confirms the stale target never appears. The full cross of flags, group select, sense, ignored bit and usable qualifier is swept, with varying addresses and extreme offsets.

// File: rtl/fp4br_pkg.sv
package fp4br_pkg;
  localparam logic [5:0] OP_COP1  = 6'b010001;
  localparam logic [4:0] SUB_ANY4 = 5'b01010;

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  sub;
    logic [2:0]  grp_sel;
    logic        nd_ign;
    logic        sense;
    logic [15:0] off;
  } br_word_t;
endpackage

// File: rtl/fp4br_decode.sv
module fp4br_decode
  import fp4br_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output logic        hit_o,
  output logic [2:0]  sel_o,
  output logic        sense_o,
  output logic [15:0] off_o,
  output logic        mis_o
);
  localparam int GRP_LSB = $clog2(GROUP);

  br_word_t w;
  assign w       = br_word_t'(instr_i);
  assign hit_o   = valid_i && (w.op == OP_COP1) && (w.sub == SUB_ANY4);
  assign sel_o   = w.grp_sel;
  assign sense_o = w.sense;
  assign off_o   = w.off;
  assign mis_o   = |w.grp_sel[GRP_LSB-1:0];
endmodule

// File: rtl/fp4br_cond.sv
module fp4br_cond #(
  parameter int NUM_FLAGS = 8,
  parameter int GROUP     = 4
) (
  input  logic [NUM_FLAGS-1:0]         flags_i,
  input  logic [$clog2(NUM_FLAGS)-1:0] sel_i,
  input  logic                         sense_i,
  output logic                         cond_o
);
  localparam int NUM_GRP = NUM_FLAGS / GROUP;
  localparam int SEL_W   = $clog2(NUM_FLAGS);
  localparam int GRP_LSB = $clog2(GROUP);

  logic [NUM_GRP-1:0] any_set, all_set;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign any_set[g] = |flags_i[g*GROUP +: GROUP];
    assign all_set[g] = &flags_i[g*GROUP +: GROUP];
  end

  logic [SEL_W-GRP_LSB-1:0] gi;
  assign gi     = sel_i[SEL_W-1:GRP_LSB];
  // false sense: some flag is clear
  assign cond_o = sense_i ? any_set[gi] : ~all_set[gi];
endmodule

// File: rtl/fp4br_target.sv
module fp4br_target #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] tgt_o
);
  localparam int EXT = AW - OW - 2;

  logic [AW-1:0] disp;
  assign disp  = {{EXT{off_i[OW-1]}}, off_i, 2'b00};
  // base is the delay-slot address
  assign tgt_o = pc_i + AW'(4) + disp;
endmodule

// File: rtl/fp4_branch_resolver.sv
module fp4_branch_resolver #(
  parameter int NUM_FLAGS = 8,
  parameter int GROUP     = 4,
  parameter int AW        = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [31:0]          instr_i,
  input  logic [AW-1:0]        pc_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 cop_usable_i,
  output logic                 recog_o,
  output logic                 taken_o,
  output logic [AW-1:0]        target_o,
  output logic                 misalign_o,
  output logic                 cop_unusable_o,
  output logic                 redirect_o,
  output logic [AW-1:0]        redirect_pc_o
);
  localparam int SEL_W = $clog2(NUM_FLAGS);

  logic        hit, sense, mis, cond;
  logic [2:0]  sel;
  logic [15:0] off;
  logic [AW-1:0] tgt;

  logic          pend_q, redir_q;
  logic [AW-1:0] tgt_q, redir_pc_q;

  fp4br_decode #(.GROUP(GROUP)) u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .hit_o   (hit),
    .sel_o   (sel),
    .sense_o (sense),
    .off_o   (off),
    .mis_o   (mis)
  );

  fp4br_cond #(.NUM_FLAGS(NUM_FLAGS), .GROUP(GROUP)) u_cond (
    .flags_i (flags_i),
    .sel_i   (sel[SEL_W-1:0]),
    .sense_i (sense),
    .cond_o  (cond)
  );

  fp4br_target #(.AW(AW), .OW(16)) u_tgt (
    .pc_i  (pc_i),
    .off_i (off),
    .tgt_o (tgt)
  );

  assign recog_o        = hit;
  assign cop_unusable_o = hit && !cop_usable_i;
  assign misalign_o     = hit && cop_usable_i && mis;
  assign taken_o        = hit && cop_usable_i && !mis && cond && !pend_q;
  assign target_o       = tgt;
  assign redirect_o     = redir_q;
  assign redirect_pc_o  = redir_pc_q;

  // redirect lands after the delay-slot step is consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      tgt_q      <= '0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= 1'b0;
      if (valid_i) begin
        if (pend_q) begin
          pend_q     <= 1'b0;
          redir_q    <= 1'b1;
          redir_pc_q <= tgt_q;
        end else if (taken_o) begin
          pend_q <= 1'b1;
          tgt_q  <= tgt;
        end
      end
    end
  end
endmodule

// File: rtl/fp4br_chk.sv
module fp4br_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          recog_o,
  input logic          taken_o,
  input logic          misalign_o,
  input logic          cop_unusable_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o,
  input logic          pend_q,
  input logic [AW-1:0] tgt_q
);
  // R1
  taken_needs_recog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> recog_o);
  // R4
  misalign_blocks_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !taken_o);
  // R5
  unusable_blocks_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_unusable_o |-> (!taken_o && !misalign_o));
  // R8
  redirect_after_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && valid_i) |=> (redirect_o && redirect_pc_o == $past(tgt_q)));
  // R8
  redirect_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
  // R9
  no_accept_when_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !taken_o);
endmodule

bind fp4_branch_resolver fp4br_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .recog_o        (recog_o),
  .taken_o        (taken_o),
  .misalign_o     (misalign_o),
  .cop_unusable_o (cop_unusable_o),
  .redirect_o     (redirect_o),
  .redirect_pc_o  (redirect_pc_o),
  .pend_q         (pend_q),
  .tgt_q          (tgt_q)
);

// File: tb/tb_fp4_branch_resolver.sv
`timescale 1ns/1ps
module tb_fp4_branch_resolver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [7:0]  flags_i = '0;
  logic        cop_usable_i = 1'b0;
  logic        recog_o, taken_o, misalign_o, cop_unusable_o, redirect_o;
  logic [31:0] target_o, redirect_pc_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  fp4_branch_resolver dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .flags_i(flags_i), .cop_usable_i(cop_usable_i),
    .recog_o(recog_o), .taken_o(taken_o), .target_o(target_o),
    .misalign_o(misalign_o), .cop_unusable_o(cop_unusable_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] sub,
      input logic [2:0] cc, input logic nd, input logic tf, input logic [15:0] off);
    return {op, sub, cc, nd, tf, off};
  endfunction

  function automatic logic [31:0] exp_tgt(input logic [31:0] pc, input logic [15:0] off);
    int sx;
    sx = int'(off[15] ? int'(off) - 65536 : int'(off)) * 4;
    return pc + 32'd4 + 32'(sx);
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] pc,
      input logic [7:0] fl, input logic us);
    @(negedge clk_i);
    valid_i = v; instr_i = ins; pc_i = pc; flags_i = fl; cop_usable_i = us;
    #1;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] good;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 redirect in reset", {31'd0, redirect_o}, 32'd0);
    rst_ni = 1'b1;

    // R1 opcode field bits
    good = mk(6'b010001, 5'b01010, 3'd0, 1'b0, 1'b1, 16'd0);
    step(1'b1, good, 32'h1000, 8'hFF, 1'b0);
    chk("R1 recog good", {31'd0, recog_o}, 32'd1);
    for (int b = 21; b < 32; b++) begin
      step(1'b1, good ^ (32'd1 << b), 32'h1000, 8'hFF, 1'b0);
      chk("R1 recog flipped bit", {31'd0, recog_o}, 32'd0);
    end
    step(1'b0, good, 32'h1000, 8'hFF, 1'b1);
    chk("R1 recog no valid", {31'd0, recog_o}, 32'd0);
    chk("R1 taken no valid", {31'd0, taken_o}, 32'd0);

    // full sweep
    for (int f = 0; f < 256; f++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 8; k++) begin
          logic tf, nd, us, mis, cnd, et;
          logic [3:0]  grp;
          logic [15:0] off;
          logic [31:0] pc, et_tgt;
          string tag;
          int idx;
          tf = k[0]; nd = k[1]; us = k[2];
          idx = f * 64 + c * 8 + k;
          pc  = (32'(idx) * 32'h9E3779B1) & 32'hFFFF_FFFC;
          off = 16'(idx * 40503);
          if (idx % 4 == 0) off = 16'h8000;
          if (idx % 4 == 1) off = 16'h7FFF;
          if (idx % 8 == 2) pc = 32'hFFFF_FFF0;
          mis = (c % 4) != 0;
          grp = 4'((f >> (c - c % 4)) & 15);
          cnd = tf ? (grp != 4'h0) : (grp != 4'hF);
          et  = us && !mis && cnd;
          et_tgt = exp_tgt(pc, off);
          tag = nd ? "R7" : (tf ? "R2" : "R3");
          step(1'b1, mk(6'b010001, 5'b01010, 3'(c), nd, tf, off), pc, 8'(f), us);
          chk("R1 recog sweep", {31'd0, recog_o}, 32'd1);
          chk({tag, " taken"}, {31'd0, taken_o}, {31'd0, et});
          chk(mis ? "R4 misalign" : "R4 aligned", {31'd0, misalign_o}, {31'd0, us && mis});
          chk("R5 unusable", {31'd0, cop_unusable_o}, {31'd0, !us});
          chk("R6 target", target_o, et_tgt);
          if (et) begin
            step(1'b1, 32'd0, pc + 32'd4, 8'(f), us);
            chk("R8 no redirect in slot", {31'd0, redirect_o}, 32'd0);
            step(1'b0, 32'd0, 32'd0, 8'd0, 1'b0);
            chk("R8 redirect pulse", {31'd0, redirect_o}, 32'd1);
            chk("R8 redirect pc", redirect_pc_o, et_tgt);
          end else begin
            step(1'b0, 32'd0, 32'd0, 8'd0, 1'b0);
            chk("R8 no redirect untaken", {31'd0, redirect_o}, 32'd0);
          end
        end
      end
    end

    // R9 taken branch in delay slot
    step(1'b1, mk(6'b010001, 5'b01010, 3'd0, 1'b0, 1'b1, 16'd1), 32'h100, 8'h01, 1'b1);
    chk("R9 first taken", {31'd0, taken_o}, 32'd1);
    step(1'b1, mk(6'b010001, 5'b01010, 3'd4, 1'b0, 1'b1, 16'd8), 32'h104, 8'hF0, 1'b1);
    chk("R9 slot recog", {31'd0, recog_o}, 32'd1);
    chk("R9 slot not taken", {31'd0, taken_o}, 32'd0);
    step(1'b1, 32'd0, 32'h200, 8'h00, 1'b1);
    chk("R9 redirect first", {31'd0, redirect_o}, 32'd1);
    chk("R9 redirect pc first", redirect_pc_o, 32'h108);
    step(1'b1, 32'd0, 32'h204, 8'h00, 1'b1);
    chk("R9 no second redirect", {31'd0, redirect_o}, 32'd0);
    step(1'b0, 32'd0, 32'h0, 8'h00, 1'b1);
    chk("R9 no second redirect late", {31'd0, redirect_o}, 32'd0);

    // R10 reset while pending
    step(1'b1, mk(6'b010001, 5'b01010, 3'd0, 1'b0, 1'b0, 16'd3), 32'h400, 8'h00, 1'b1);
    chk("R10 setup taken", {31'd0, taken_o}, 32'd1);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R10 redirect during reset", {31'd0, redirect_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 32'd0, 32'h404, 8'h00, 1'b1);
    step(1'b0, 32'd0, 32'h0, 8'h00, 1'b1);
    chk("R10 stale redirect dropped", {31'd0, redirect_o}, 32'd0);
    step(1'b1, mk(6'b010001, 5'b01010, 3'd0, 1'b0, 1'b1, 16'd0), 32'h500, 8'h0F, 1'b1);
    chk("R10 accepts after reset", {31'd0, taken_o}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule